// File: doc/BRIEF.md
# Dual-Mode Decrementer Timer

This block is a 32-bit down counter that requests an interrupt when its count crosses a chosen point. Software loads the count through a write port and can read it back at any time. Each cycle in which the tick enable is high takes one from the count. A static mode input picks one of two behaviours.

In sign-transition mode the count runs freely. It passes through zero and wraps into negative values, and the interrupt fires on the step from 0x00000000 to 0xFFFFFFFF. In zero-stop mode the interrupt fires on the step from 1 to 0, and the count then parks at zero.

The interrupt status is sticky and is cleared by an explicit pulse. A phase machine records whether the count is parked at zero. Its states are LIVE (the count is non-zero) and HELD (the count is zero). Its transitions are:
- LOAD: a write moves the machine to HELD for a zero value and to LIVE otherwise.
- STEP: a tick on a count of 1 moves LIVE to HELD. In sign-transition mode a tick moves HELD to LIVE (the wrap).
- PARK: in zero-stop mode a tick leaves HELD where it is.
- IDLE: no write and no tick, so nothing changes.

The interrupt latch is a second machine. It moves from CLEAR to PEND on an event and from PEND back to CLEAR on a clear pulse.

Top module: `dec_timer`

## Requirements
- R1: Reset sets count_o to 0 and irq_o to 0.
- R2: When wr_en_i is high, the count takes wr_data_i on the next edge and any tick in that cycle is ignored. A write never raises the interrupt, whatever sign bit it gives the count.
- R3: With no write, each cycle with tick_i high takes one from the count. The only exception is a count held at zero in zero-stop mode. With tick_i low the count does not change.
- R4: With mode_sign_i = 1 (sign-transition), a tick on a count of 0x00000000 gives 0xFFFFFFFF and raises the interrupt. Later ticks keep counting down (0xFFFFFFFE and so on).
- R5: With mode_sign_i = 1, no other change of the most significant bit raises the interrupt. This includes a tick from 0x80000000 to 0x7FFFFFFF.
- R6: With mode_sign_i = 0 (zero-stop), a tick on a count of 1 gives 0 and raises the interrupt.
- R7: With mode_sign_i = 0, a count of zero stays at zero on every tick and never raises the interrupt again.
- R8: The interrupt status stays set until a cycle with clr_i high and then drops. An event in the same cycle as clr_i leaves it set.
- R9: irq_o equals the interrupt status bit at all times. It is set on the same edge as the count update that raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sign_i | input | 1 | 1 = sign-transition mode, 0 = zero-stop mode (static) |
| tick_i | input | 1 | Decrement enable |
| wr_en_i | input | 1 | Software load strobe |
| wr_data_i | input | 32 | Value to load |
| clr_i | input | 1 | Clear pulse for the interrupt status |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The assertions check the following on every cycle:
- a write loads the count;
- a tick takes one from the count;
- the count holds without a tick;
- the wrap through zero in sign-transition mode sets the interrupt;
- a count of zero in zero-stop mode stays at zero;
- the interrupt status is sticky;
- a write alone never raises the interrupt.

Some behaviours can only be shown by the bench's scenarios, because each needs a specific run of cycles. These are the single interrupt per wrap, the lack of an event when the sign bit falls through 0x80000000, the 1-to-0 event followed by no re-trigger, and the case where a clear meets an event in the same cycle.

// File: rtl/dtm_pkg.sv
`timescale 1ns/1ps
package dtm_pkg;

    // Phase of the counter: whether it currently rests at zero.
    typedef enum logic {
        PH_LIVE = 1'b0,
        PH_HELD = 1'b1
    } phase_e;

    // Operation selected for this cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2,
        OP_PARK = 2'd3
    } op_e;

    // Interrupt latch state.
    typedef enum logic {
        IRQ_CLEAR = 1'b0,
        IRQ_PEND  = 1'b1
    } irq_e;

endpackage

// File: rtl/dtm_count_core.sv
`timescale 1ns/1ps
module dtm_count_core
    import dtm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sign,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             evt
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] count_q, count_d;
    op_e              op;

    // Operation select: a write wins over a tick.
    always_comb begin
        if (wr_en) begin
            op = OP_LOAD;
        end else if (tick) begin
            if (phase_q == PH_HELD && !mode_sign) begin
                op = OP_PARK;
            end else begin
                op = OP_STEP;
            end
        end else begin
            op = OP_IDLE;
        end
    end

    // Next count and next phase.
    always_comb begin
        count_d = count_q;
        phase_d = phase_q;
        unique case (op)
            OP_LOAD: begin
                count_d = wr_data;
                phase_d = (wr_data == CNT_ZERO) ? PH_HELD : PH_LIVE;
            end
            OP_STEP: begin
                count_d = count_q - CNT_ONE;
                phase_d = (count_q == CNT_ONE) ? PH_HELD : PH_LIVE;
            end
            OP_PARK: begin
                count_d = count_q;
                phase_d = PH_HELD;
            end
            OP_IDLE: begin
                count_d = count_q;
                phase_d = phase_q;
            end
            default: begin
                count_d = count_q;
                phase_d = phase_q;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_HELD;
            count_q <= CNT_ZERO;
        end else begin
            phase_q <= phase_d;
            count_q <= count_d;
        end
    end

    // Event detection: only a tick can produce an event.
    always_comb begin
        evt = 1'b0;
        if (op == OP_STEP) begin
            if (mode_sign) begin
                evt = (phase_q == PH_HELD);
            end else begin
                evt = (count_q == CNT_ONE);
            end
        end
    end

    assign count = count_q;

endmodule

// File: rtl/dtm_irq_latch.sv
`timescale 1ns/1ps
module dtm_irq_latch
    import dtm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic irq
);

    irq_e st_q, st_d;

    // Next state: a new event wins over a clear.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_CLEAR: st_d = evt ? IRQ_PEND : IRQ_CLEAR;
            IRQ_PEND:  st_d = (clr && !evt) ? IRQ_CLEAR : IRQ_PEND;
            default:   st_d = IRQ_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IRQ_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    // Output process.
    always_comb begin
        irq = (st_q == IRQ_PEND);
    end

endmodule

// File: rtl/dec_timer.sv
`timescale 1ns/1ps
module dec_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sign_i,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);

    logic evt;

    dtm_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sign (mode_sign_i),
        .tick      (tick_i),
        .wr_en     (wr_en_i),
        .wr_data   (wr_data_i),
        .count     (count_o),
        .evt       (evt)
    );

    dtm_irq_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr_i),
        .irq   (irq_o)
    );

endmodule

// File: rtl/dec_timer_chk.sv
`timescale 1ns/1ps
module dec_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sign_i,
    input logic             tick_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic             clr_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONES = '1;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> count_o == $past(wr_data_i));

    p_write_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !irq_o) |=> !irq_o);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_en_i && (mode_sign_i || count_o != ZERO))
        |=> count_o == $past(count_o) - CNT_W'(1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(count_o));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sign_i && tick_i && !wr_en_i && count_o == ZERO)
        |=> (count_o == ONES && irq_o));

    p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sign_i && !wr_en_i && count_o == ZERO) |=> count_o == ZERO);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);

endmodule

bind dec_timer dec_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sign_i (mode_sign_i),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .clr_i       (clr_i),
    .count_o     (count_o),
    .irq_o       (irq_o)
);

// File: tb/dec_timer_bench.sv
`timescale 1ns/1ps
module dec_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sign_i = 1'b1;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        clr_i = 1'b0;
    logic [31:0] count_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [31:0] m_cnt;
    logic        m_sts;

    // Scoreboard queues.
    logic [31:0] q_cnt[$];
    logic        q_irq[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    dec_timer u_dec_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sign_i (mode_sign_i),
        .tick_i      (tick_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .clr_i       (clr_i),
        .count_o     (count_o),
        .irq_o       (irq_o)
    );

    task automatic check(string tag, logic [31:0] c_exp, logic i_exp);
        n_run++;
        if (count_o !== c_exp || irq_o !== i_exp) begin
            n_fail++;
            $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
                     tag, count_o, irq_o, c_exp, i_exp);
        end
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sign_i = mode;
        tick_i = 1'b0; wr_en_i = 1'b0; clr_i = 1'b0; wr_data_i = '0;
        @(negedge clk);
        @(negedge clk);
        m_cnt = '0;
        m_sts = 1'b0;
        check("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    // Driver: applies one cycle of stimulus and queues the expectation.
    task automatic step(string tag, logic tk, logic wr, logic [31:0] d, logic cl);
        logic ev;
        @(negedge clk);
        tick_i = tk; wr_en_i = wr; wr_data_i = d; clr_i = cl;
        ev = 1'b0;
        if (wr) begin
            m_cnt = d;
        end else if (tk) begin
            if (mode_sign_i) begin
                ev = (m_cnt == 32'h0);
                m_cnt = m_cnt - 32'd1;
            end else if (m_cnt != 32'h0) begin
                ev = (m_cnt == 32'd1);
                m_cnt = m_cnt - 32'd1;
            end
        end
        if (ev) m_sts = 1'b1;
        else if (cl) m_sts = 1'b0;
        q_cnt.push_back(m_cnt);
        q_irq.push_back(m_sts);
        q_tag.push_back(tag);
    endtask

    task automatic quiet();
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0; clr_i = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_cnt.size() > 0) begin
                check(q_tag.pop_front(), q_cnt.pop_front(), q_irq.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Sign-transition mode
        do_reset(1'b1);
        step("R4 wrap from zero", 1, 0, 0, 0);
        step("R4 keeps counting", 1, 0, 0, 0);
        step("R9 sticky idle", 0, 0, 0, 0);
        step("R3 hold without tick", 0, 0, 0, 0);
        step("R8 clear", 0, 0, 0, 1);
        step("R2 load 0x80000000", 0, 1, 32'h8000_0000, 0);
        step("R5 msb fall no event", 1, 0, 0, 0);
        step("R2 write sets msb no irq", 0, 1, 32'hFFFF_FFFF, 0);
        step("R2 write wins over tick", 1, 1, 32'd2, 0);
        step("R3 step to 1", 1, 0, 0, 0);
        step("R3 step to 0", 1, 0, 0, 0);
        step("R8 clear with event keeps set", 1, 0, 0, 1);
        step("R8 clear drops", 1, 0, 0, 1);
        step("R4 one event per wrap", 1, 0, 0, 0);
        quiet();
        // Zero-stop mode
        do_reset(1'b0);
        step("R7 tick at zero holds", 1, 0, 0, 0);
        step("R2 load 3", 0, 1, 32'd3, 0);
        step("R3 step to 2", 1, 0, 0, 0);
        step("R3 step to 1", 1, 0, 0, 0);
        step("R6 one to zero fires", 1, 0, 0, 0);
        step("R7 held at zero", 1, 0, 0, 0);
        step("R8 clear", 1, 0, 0, 1);
        step("R7 no retrigger", 1, 0, 0, 0);
        step("R7 no retrigger again", 1, 0, 0, 0);
        step("R2 write zero no irq", 0, 1, 32'h0, 0);
        step("R2 load 1", 0, 1, 32'd1, 0);
        step("R8 event beats clear", 1, 0, 0, 1);
        step("R9 stays set", 0, 0, 0, 0);
        quiet();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule